// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine of a non-pipelined 32-bit processor that executes one instruction at a time. Every instruction walks through five phases, fetch, decode, execute, memory and write-back, one clock each, and the next instruction's fetch only begins after the previous write-back. The sequencer owns the program counter. It takes the instruction class from the decoder and the taken flag and target address from the execute logic. It drives the PC load enable, the PC source select, the register-file write enable, the data-memory write enable, a permanently active instruction-memory read enable and a one-hot phase indicator.

The instruction class is captured at the end of decode. The taken flag and the target are captured at the end of execute. Values on those inputs at any other time are ignored. The PC is written during write-back, which is one clock before the following fetch. The new fetch therefore already sees the updated address.

Top module: `mc_seq_ctrl`

## Requirements
- R1: A synchronous reset puts the phase indicator at fetch (`phase` = 5'b00001), sets `pc` to RESET_PC and holds `rf_we`, `dm_we`, `pc_load` and `pc_sel` low in the cycle after it.
- R2: `phase` is always one-hot, with bit 0 for fetch, bit 1 for decode, bit 2 for execute, bit 3 for memory and bit 4 for write-back. Each phase lasts one cycle and the order fetch, decode, execute, memory, write-back, fetch repeats.
- R3: `imem_re` is high in every cycle.
- R4: `dm_we` is high only in the memory phase of an instruction whose class is store (code 3), and then for exactly that one cycle.
- R5: `rf_we` is high only in the write-back phase. It is high there exactly when the class is ALU register (0), ALU immediate (1), load (2) or jump-and-link (5). It stays low for store (3) and branch (4).
- R6: `pc_load` is high exactly in the write-back phase, and `pc` changes only at the clock edge that ends a cycle with `pc_load` high (or on reset).
- R7: After write-back, `pc` equals the captured target when the class is jump-and-link or the class is branch with the captured taken flag high. Otherwise it equals the old `pc` plus 4, modulo 2^XLEN. During write-back, `pc_sel` is high exactly when the target is chosen, and it is low in all other phases.
- R8: `op_class` is sampled only at the end of decode, and `br_taken` and `tgt_addr` only at the end of execute. Their values in other cycles have no effect on any output.
- R9: Class codes 6 and 7 write neither the register file nor the data memory, and advance `pc` by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_class | input | 3 | Decoded instruction class, valid in decode |
| br_taken | input | 1 | Branch condition result, valid in execute |
| tgt_addr | input | XLEN | Branch or jump target, valid in execute |
| imem_re | output | 1 | Instruction-memory read enable, always high |
| pc | output | XLEN | Program counter |
| pc_load | output | 1 | PC register load enable |
| pc_sel | output | 1 | PC source: 1 selects target, 0 selects PC+4 |
| rf_we | output | 1 | Register-file write enable |
| dm_we | output | 1 | Data-memory write enable |
| phase | output | 5 | One-hot phase indicator |

## Verification
The bench builds the block with its defaults, XLEN = 32 and RESET_PC = 0. With these values, a jump to 32'hFFFFFFFC followed by a non-redirecting instruction puts the PC+4 wrap back to zero within reach. The PC after reset is then the same as the address reached by that wrap. Random classes, including the two unused codes, are mixed with random garbage on the inputs outside their capture phases. A reset lands in the middle of an instruction, and the phase and PC model must restart with it.

// File: rtl/mc_seq_ctrl.sv
`timescale 1ns/1ps
module mc_seq_ctrl #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      op_class,
  input  logic            br_taken,
  input  logic [XLEN-1:0] tgt_addr,
  output logic            imem_re,
  output logic [XLEN-1:0] pc,
  output logic            pc_load,
  output logic            pc_sel,
  output logic            rf_we,
  output logic            dm_we,
  output logic [4:0]      phase
);
  localparam int NPH = 5;
  localparam logic [2:0] C_ALUR = 3'd0;
  localparam logic [2:0] C_ALUI = 3'd1;
  localparam logic [2:0] C_LOAD = 3'd2;
  localparam logic [2:0] C_STOR = 3'd3;
  localparam logic [2:0] C_BRAN = 3'd4;
  localparam logic [2:0] C_JAL  = 3'd5;
  localparam logic [2:0] C_IDLE = 3'd7;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [NPH-1:0]  ph_q;
  logic [2:0]      cls_q;
  logic            tk_q;
  logic [XLEN-1:0] tgt_q;
  logic [XLEN-1:0] pc_q;

  wire in_dec = ph_q[1];
  wire in_ex  = ph_q[2];
  wire in_mem = ph_q[3];
  wire in_wb  = ph_q[4];

  wire writes_reg = (cls_q == C_ALUR) || (cls_q == C_ALUI) ||
                    (cls_q == C_LOAD) || (cls_q == C_JAL);
  wire redirect   = (cls_q == C_JAL) || ((cls_q == C_BRAN) && tk_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= NPH'(1);
      cls_q <= C_IDLE;
      tk_q  <= 1'b0;
      tgt_q <= '0;
      pc_q  <= RESET_PC;
    end else begin
      ph_q <= {ph_q[NPH-2:0], ph_q[NPH-1]};
      if (in_dec) cls_q <= op_class;
      if (in_ex) begin
        tk_q  <= br_taken;
        tgt_q <= tgt_addr;
      end
      if (in_wb) pc_q <= redirect ? tgt_q : pc_q + STEP;
    end
  end

  assign imem_re = 1'b1;
  assign pc      = pc_q;
  assign phase   = ph_q;
  assign pc_load = in_wb;
  assign pc_sel  = in_wb & redirect;
  assign rf_we   = in_wb & writes_reg;
  assign dm_we   = in_mem & (cls_q == C_STOR);
endmodule

// File: rtl/seq_ctrl_chk.sv
`timescale 1ns/1ps
module seq_ctrl_chk #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      op_class,
  input logic            br_taken,
  input logic [XLEN-1:0] tgt_addr,
  input logic            imem_re,
  input logic [XLEN-1:0] pc,
  input logic            pc_load,
  input logic            pc_sel,
  input logic            rf_we,
  input logic            dm_we,
  input logic [4:0]      phase
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (phase == 5'b00001 && pc == RESET_PC && !rf_we && !dm_we && !pc_load));
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(phase) == 1);
  a_r2_f2d: assert property (@(posedge clk) disable iff (rst) phase[0] |=> phase[1]);
  a_r2_d2e: assert property (@(posedge clk) disable iff (rst) phase[1] |=> phase[2]);
  a_r2_e2m: assert property (@(posedge clk) disable iff (rst) phase[2] |=> phase[3]);
  a_r2_m2w: assert property (@(posedge clk) disable iff (rst) phase[3] |=> phase[4]);
  a_r2_w2f: assert property (@(posedge clk) disable iff (rst) phase[4] |=> phase[0]);
  a_r4_dm_phase: assert property (@(posedge clk) disable iff (rst) dm_we |-> phase[3]);
  a_r4_dm_pulse: assert property (@(posedge clk) disable iff (rst) dm_we |=> !dm_we);
  a_r5_rf_phase: assert property (@(posedge clk) disable iff (rst) rf_we |-> phase[4]);
  a_r6_load_wb: assert property (@(posedge clk) disable iff (rst) pc_load == phase[4]);
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (rst) !pc_load |=> $stable(pc));
  a_r7_sel_wb: assert property (@(posedge clk) disable iff (rst) pc_sel |-> pc_load);
endmodule

bind mc_seq_ctrl seq_ctrl_chk #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_chk (.*);

// File: tb/mc_seq_ctrl_test.sv
`timescale 1ns/1ps
module mc_seq_ctrl_test;
  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] RPC = '0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] op_class = '0;
  logic br_taken = 1'b0;
  logic [XLEN-1:0] tgt_addr = '0;
  logic imem_re, pc_load, pc_sel, rf_we, dm_we;
  logic [XLEN-1:0] pc;
  logic [4:0] phase;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mc_seq_ctrl #(.XLEN(XLEN), .RESET_PC(RPC)) uut (
    .clk(clk), .rst(rst), .op_class(op_class), .br_taken(br_taken),
    .tgt_addr(tgt_addr), .imem_re(imem_re), .pc(pc), .pc_load(pc_load),
    .pc_sel(pc_sel), .rf_we(rf_we), .dm_we(dm_we), .phase(phase));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit f_writes(input logic [2:0] c);
    return c == 3'd0 || c == 3'd1 || c == 3'd2 || c == 3'd5;
  endfunction

  function automatic bit f_redir(input logic [2:0] c, input bit t);
    return c == 3'd5 || (c == 3'd4 && t);
  endfunction

  int m_ph;
  logic [XLEN-1:0] m_pc, m_tgt;
  logic [2:0] m_cls;
  bit m_tk;
  logic [2:0] i_cls;
  bit i_tk;
  logic [XLEN-1:0] i_tgt;

  task automatic pick(input int n);
    i_cls = 3'($urandom_range(0, 7));
    i_tk  = 1'($urandom);
    i_tgt = {$urandom} & ~32'h3;
    case (n)
      0: begin i_cls = 3'd5; i_tgt = 32'hFFFF_FFFC; end
      1: i_cls = 3'd0;
      2: begin i_cls = 3'd4; i_tk = 0; i_tgt = 32'h100; end
      3: begin i_cls = 3'd4; i_tk = 1; i_tgt = 32'h40; end
      4: i_cls = 3'd3;
      5: i_cls = 3'd6;
      6: i_cls = 3'd7;
      7: i_cls = 3'd2;
      8: i_cls = 3'd1;
      default: ;
    endcase
  endtask

  task automatic check_now();
    string cr;
    cr = (m_cls >= 3'd6) ? "R9" : "R5";
    chk("R2 phase", 64'(phase), 64'(5'b1 << m_ph));
    chk("R3 imem_re", 64'(imem_re), 64'd1);
    chk("R6 pc_load", 64'(pc_load), 64'(m_ph == 4));
    chk("R7 pc_sel", 64'(pc_sel), 64'(m_ph == 4 && f_redir(m_cls, m_tk)));
    chk({cr, " rf_we"}, 64'(rf_we), 64'(m_ph == 4 && f_writes(m_cls)));
    chk((m_cls >= 3'd6) ? "R9 dm_we" : "R4 dm_we", 64'(dm_we), 64'(m_ph == 3 && m_cls == 3'd3));
    chk("R7 R8 pc", 64'(pc), 64'(m_pc));
  endtask

  initial begin
    void'($urandom(32'd20240731));
    @(negedge clk);
    @(negedge clk);
    m_ph = 0; m_pc = RPC; m_cls = 3'd7; m_tk = 0; m_tgt = '0;
    chk("R1 phase", 64'(phase), 64'd1);
    chk("R1 pc", 64'(pc), 64'(RPC));
    chk("R1 enables", 64'({rf_we, dm_we, pc_load, pc_sel}), 64'd0);
    rst = 1'b0;
    for (int n = 0; n < 600; n++) begin
      pick(n);
      for (int p = 0; p < 5; p++) begin
        check_now();
        op_class = (p == 1) ? i_cls : 3'($urandom);
        br_taken = (p == 2) ? i_tk : 1'($urandom);
        tgt_addr = (p == 2) ? i_tgt : XLEN'($urandom);
        if (n == 300 && p == 2) begin
          rst = 1'b1;
          @(negedge clk);
          rst = 1'b0;
          m_ph = 0; m_pc = RPC; m_cls = 3'd7; m_tk = 0;
          chk("R1 phase midrun", 64'(phase), 64'd1);
          chk("R1 pc midrun", 64'(pc), 64'(RPC));
          chk("R1 enables midrun", 64'({rf_we, dm_we, pc_load, pc_sel}), 64'd0);
          break;
        end
        case (p)
          1: m_cls = op_class;
          2: begin m_tk = br_taken; m_tgt = tgt_addr; end
          4: m_pc = f_redir(m_cls, m_tk) ? m_tgt : m_pc + XLEN'(4);
          default: ;
        endcase
        m_ph = (p + 1) % 5;
        @(negedge clk);
        if (n == 1 && p == 4) chk("R7 wrap to zero", 64'(pc), 64'd0);
        if (n == 2 && p == 4) chk("R7 not taken", 64'(pc), 64'd4);
        if (n == 3 && p == 4) chk("R7 taken", 64'(pc), 64'h40);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule